// File: doc/BRIEF.md
# System Reset Sequencer

This block gathers every cause that can restart the processor and turns them into one synchronous system reset. The causes are a power-on voltage comparison, an external active-low pin, a watchdog overflow, an illegal opcode, a fault on the data-retention supply and an illegal memory access. The external pin only counts as a reset when an option bit enables it. It must also stay low for a minimum number of sampling cycles after a two-flop synchronizer. Internal causes are stretched so that the reset covers a fixed number of cycles after the cause goes away.

While the reset is active, the block disables the three oscillator enables and marks the external clock input as invalid. It also drives the reset-time states of two special port pins. The level on those pins depends on which cause is active. A six-bit cause register records each cause that has occurred, and software clears it by writing ones. After the reset releases, a small sequencer reads the low byte of the restart vector from address 0x0000 and the high byte from 0x0001. It then presents the 16-bit value to the core and pulses a start strobe.

Top module: `rst_hub`

## Requirements
- R1: With the pin enabled, the external pin causes a reset only if its synchronized value stays low for at least MIN_LOW consecutive clock cycles. A shorter low pulse causes no reset and leaves the cause register unchanged.
- R2: While `pin_rst_en` is 0, the external pin has no effect on `sys_rst` or on `cause`, however long it stays low.
- R3: Watchdog overflow, illegal opcode, retention fault and memory fault each assert `sys_rst` from the next clock edge. `sys_rst` then stays high for exactly STRETCH cycles after the last cycle in which any cause was sampled active.
- R4: An illegal-opcode reset occurs only when `op_exec` is 1, `opcode` equals 8'hFF and `dbg_mode` is 0. Any other opcode, or the same opcode with `dbg_mode` at 1, causes no reset.
- R5: While `sys_rst` is 1, `osc_en` is 3'b000 and `extclk_ok` is 0. Otherwise `osc_en` is 3'b111 and `extclk_ok` is 1.
- R6: While a reset caused by the external pin or by the retention fault is active, pin A is released (`pin_a_oe` = 0, `pin_a_pu` = 0). During any other reset, and after release, pin A is driven high with `pin_a_oe` = 1 and `pin_a_pu` = 1.
- R7: `pin_b_pu` is 0 while a reset caused by the external pin is active. During every other reset, and after release, it is 1.
- R8: Each bit of `cause` records one source: bit0 power-on, bit1 external pin, bit2 watchdog, bit3 illegal opcode, bit4 retention fault, bit5 memory fault. Power-on sets the register to 6'b000001. An accepted external reset sets it to 6'b000010. Other causes OR their bit in, and writing 1 to a bit of `cause_clr` clears that bit.
- R9: After release, the block reads address 0x0000 and then 0x0001. Each read holds `mem_req` until `mem_ack` arrives. The block then sets `pc_out` to {byte at 0x0001, byte at 0x0000} and pulses `cpu_start` for exactly one cycle.
- R10: A reset that arrives during the vector fetch abandons the fetch without a `cpu_start`. The fetch then restarts from 0x0000 after the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and system clock |
| spor_n | input | 1 | Power-on voltage comparator output, active low, asynchronous |
| ext_rst_pin | input | 1 | Raw level of the external reset pin |
| pin_rst_en | input | 1 | Option bit that enables the pin as a reset |
| wdt_ovf | input | 1 | Watchdog overflow |
| op_exec | input | 1 | An opcode is being executed this cycle |
| opcode | input | 8 | Opcode being executed |
| dbg_mode | input | 1 | On-chip debug mode active |
| ret_fault | input | 1 | Retention supply below its limit |
| mem_fault | input | 1 | Illegal memory access |
| cause_clr | input | 6 | Write-one-to-clear strobe for the cause register |
| cause | output | 6 | Reset cause flags |
| sys_rst | output | 1 | System reset, active high |
| osc_en | output | 3 | Enables for the crystal, fast and slow internal oscillators |
| extclk_ok | output | 1 | External clock input may be used |
| pin_a_oe | output | 1 | Pin A drives high |
| pin_a_pu | output | 1 | Pin A pull-up enable |
| pin_b_pu | output | 1 | Pin B pull-up enable |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | 16 | Vector read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| pc_out | output | 16 | Restart address for the core |
| cpu_start | output | 1 | One-cycle start strobe |

## Verification
The assertions check the following properties on every cycle:
- The start strobe lasts one cycle and always follows an acknowledged read of 0x0001.
- The illegal-opcode flag rises only after an 0xFF opcode was executed outside debug mode.
- The external flag rises only when the pin enable was set.
- The reset never falls in the cycle just after a cause was active.

Only the bench scenarios can show the following:
- The exact stretch length after both short and held causes.
- The cycle threshold of the pin filter.
- The cause-dependent pin states.
- The flag clearing on an external reset.
- Recovery of the vector fetch when a reset interrupts it.

// File: rtl/rst_hub.sv
module rst_hub #(
  parameter int MIN_LOW = 2000,
  parameter int STRETCH = 16
) (
  input  logic        clk,
  input  logic        spor_n,
  input  logic        ext_rst_pin,
  input  logic        pin_rst_en,
  input  logic        wdt_ovf,
  input  logic        op_exec,
  input  logic [7:0]  opcode,
  input  logic        dbg_mode,
  input  logic        ret_fault,
  input  logic        mem_fault,
  input  logic [5:0]  cause_clr,
  output logic [5:0]  cause,
  output logic        sys_rst,
  output logic [2:0]  osc_en,
  output logic        extclk_ok,
  output logic        pin_a_oe,
  output logic        pin_a_pu,
  output logic        pin_b_pu,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc_out,
  output logic        cpu_start
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int SW = $clog2(STRETCH + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW);
  localparam logic [SW-1:0] HOLD    = SW'(STRETCH);

  typedef enum logic [1:0] {S_WAIT, S_LO, S_HI, S_RUN} fetch_t;

  logic [1:0]    sync_q;
  logic [LW-1:0] low_cnt;
  logic [SW-1:0] hold_cnt;
  logic          hiz_flag, extp_flag;
  logic [7:0]    lo_byte;
  fetch_t        st;

  wire ext_low = pin_rst_en & ~sync_q[1];
  wire ext_act = (low_cnt == LOW_MAX);
  wire ill_op  = op_exec & (opcode == 8'hFF) & ~dbg_mode;
  wire any_src = ext_act | wdt_ovf | ill_op | ret_fault | mem_fault;

  always_ff @(posedge clk or negedge spor_n)
    if (!spor_n) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], ext_rst_pin};

  always_ff @(posedge clk or negedge spor_n)
    if (!spor_n)       low_cnt <= '0;
    else if (!ext_low) low_cnt <= '0;
    else if (!ext_act) low_cnt <= low_cnt + 1'b1;

  always_ff @(posedge clk or negedge spor_n)
    if (!spor_n)              hold_cnt <= HOLD;
    else if (any_src)         hold_cnt <= HOLD;
    else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;

  assign sys_rst   = (hold_cnt != '0);
  assign osc_en    = {3{~sys_rst}};
  assign extclk_ok = ~sys_rst;

  always_ff @(posedge clk or negedge spor_n)
    if (!spor_n) begin
      hiz_flag  <= 1'b0;
      extp_flag <= 1'b0;
    end else begin
      if (ext_act | ret_fault) hiz_flag <= 1'b1;
      else if (!sys_rst)       hiz_flag <= 1'b0;
      if (ext_act)             extp_flag <= 1'b1;
      else if (!sys_rst)       extp_flag <= 1'b0;
    end

  assign pin_a_oe = ~(sys_rst & hiz_flag);
  assign pin_a_pu = pin_a_oe;
  assign pin_b_pu = ~(sys_rst & extp_flag);

  always_ff @(posedge clk or negedge spor_n)
    if (!spor_n)      cause <= 6'b000001;
    else if (ext_act) cause <= 6'b000010;
    else              cause <= (cause & ~cause_clr) |
                               {mem_fault, ret_fault, ill_op, wdt_ovf, 2'b00};

  always_ff @(posedge clk or negedge spor_n)
    if (!spor_n) begin
      st        <= S_WAIT;
      lo_byte   <= '0;
      pc_out    <= '0;
      cpu_start <= 1'b0;
    end else begin
      cpu_start <= 1'b0;
      if (sys_rst) st <= S_WAIT;
      else begin
        case (st)
          S_WAIT: st <= S_LO;
          S_LO:   if (mem_ack) begin
                    lo_byte <= mem_rdata;
                    st      <= S_HI;
                  end
          S_HI:   if (mem_ack) begin
                    pc_out    <= {mem_rdata, lo_byte};
                    cpu_start <= 1'b1;
                    st        <= S_RUN;
                  end
          default: st <= S_RUN;
        endcase
      end
    end

  assign mem_req  = ~sys_rst & ((st == S_LO) | (st == S_HI));
  assign mem_addr = {15'd0, st == S_HI};

  a_r2_pin_enabled: assert property (@(posedge clk) disable iff (!spor_n)
    $rose(cause[1]) |-> $past(pin_rst_en, 2));
  a_r3_no_early_release: assert property (@(posedge clk) disable iff (!spor_n)
    $fell(sys_rst) |-> !$past(wdt_ovf || ret_fault || mem_fault));
  a_r4_opcode_only: assert property (@(posedge clk) disable iff (!spor_n)
    $rose(cause[3]) |-> $past(op_exec && opcode == 8'hFF && !dbg_mode));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!spor_n)
    cpu_start |=> !cpu_start);
  a_r9_after_high_byte: assert property (@(posedge clk) disable iff (!spor_n)
    cpu_start |-> $past(mem_req && mem_ack && mem_addr == 16'h0001));
endmodule

// File: tb/rst_hub_tb_top.sv
module rst_hub_tb_top;
  localparam int MIN_LOW = 12;
  localparam int STRETCH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic spor_n, ext_rst_pin, pin_rst_en, wdt_ovf, op_exec, dbg_mode, ret_fault, mem_fault;
  logic [7:0] opcode;
  logic [5:0] cause_clr, cause;
  logic sys_rst, extclk_ok, pin_a_oe, pin_a_pu, pin_b_pu, mem_req, mem_ack, cpu_start;
  logic [2:0] osc_en;
  logic [15:0] mem_addr, pc_out, vec;
  logic [7:0] mem_rdata;
  logic ack_en;

  rst_hub #(.MIN_LOW(MIN_LOW), .STRETCH(STRETCH)) dut_i (
    .clk(clk), .spor_n(spor_n), .ext_rst_pin(ext_rst_pin), .pin_rst_en(pin_rst_en),
    .wdt_ovf(wdt_ovf), .op_exec(op_exec), .opcode(opcode), .dbg_mode(dbg_mode),
    .ret_fault(ret_fault), .mem_fault(mem_fault), .cause_clr(cause_clr), .cause(cause),
    .sys_rst(sys_rst), .osc_en(osc_en), .extclk_ok(extclk_ok), .pin_a_oe(pin_a_oe),
    .pin_a_pu(pin_a_pu), .pin_b_pu(pin_b_pu), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pc_out(pc_out), .cpu_start(cpu_start));

  assign mem_ack   = mem_req & ack_en;
  assign mem_rdata = mem_addr[0] ? vec[15:8] : vec[7:0];

  typedef struct { logic [15:0] pc; logic [5:0] cs; } boot_t;
  boot_t exp_q[$];
  int checks = 0, errors = 0, popped = 0;
  logic [15:0] last_addr = 16'hFFFF, prev_addr = 16'hFFFF;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_boot(logic [15:0] pc, logic [5:0] cs);
    boot_t b;
    b.pc = pc; b.cs = cs;
    exp_q.push_back(b);
  endtask

  always @(posedge clk) if (mem_req && mem_ack) begin
    prev_addr <= last_addr;
    last_addr <= mem_addr;
  end

  always @(negedge clk) if (cpu_start) begin
    boot_t b;
    if (exp_q.size() == 0) chk("R9 unexpected start", 1, 0);
    else begin
      b = exp_q.pop_front();
      chk("R9 pc", int'(pc_out), int'(b.pc));
      chk("R8 cause at boot", int'(cause), int'(b.cs));
      chk("R9 read order", int'({prev_addr, last_addr}), 32'h0000_0001);
      popped++;
    end
  end

  task automatic wait_boot(int target);
    int n = 0;
    while (popped < target && n < 400) begin @(negedge clk); n++; end
    chk("R9 boot reached", popped, target);
    @(negedge clk);
  endtask

  task automatic clear_cause(logic [5:0] v);
    @(negedge clk) cause_clr = v;
    @(negedge clk) cause_clr = 6'b0;
  endtask

  task automatic pulse_src(int which, int k, output int rem);
    @(negedge clk);
    case (which)
      0: wdt_ovf = 1'b1;
      1: begin op_exec = 1'b1; opcode = 8'hFF; end
      2: ret_fault = 1'b1;
      default: mem_fault = 1'b1;
    endcase
    for (int i = 0; i < k; i++) @(negedge clk);
    wdt_ovf = 0; op_exec = 0; opcode = 8'h00; ret_fault = 0; mem_fault = 0;
    rem = 0;
    while (sys_rst && rem < 100) begin rem++; @(negedge clk); end
  endtask

  task automatic ext_pulse(int n, output int seen, output int a_oe, output int b_pu);
    seen = 0; a_oe = -1; b_pu = -1;
    @(negedge clk) ext_rst_pin = 1'b0;
    for (int i = 0; i < n + 8; i++) begin
      @(negedge clk);
      if (i == n - 1) ext_rst_pin = 1'b1;
      if (sys_rst) begin
        if (seen == 0) begin a_oe = pin_a_oe; b_pu = pin_b_pu; end
        seen++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rem, seen, aoe, bpu, boots;
    spor_n = 0; ext_rst_pin = 1; pin_rst_en = 1; wdt_ovf = 0; op_exec = 0; opcode = 0;
    dbg_mode = 0; ret_fault = 0; mem_fault = 0; cause_clr = 0; ack_en = 1; vec = 16'h1234;
    boots = 0;
    expect_boot(16'h1234, 6'b000001); boots++;
    repeat (3) @(negedge clk);
    spor_n = 1;
    @(negedge clk);
    chk("R5 reset osc_en", int'(osc_en), 0);
    chk("R5 reset extclk_ok", int'(extclk_ok), 0);
    chk("R6 power-on pin A driven", int'({pin_a_oe, pin_a_pu}), 3);
    chk("R7 power-on pin B pull-up", int'(pin_b_pu), 1);
    chk("R8 power-on cause", int'(cause), 1);
    chk("R10 no request in reset", int'(mem_req), 0);
    wait_boot(boots);
    chk("R5 run osc_en", int'(osc_en), 7);
    chk("R5 run extclk_ok", int'(extclk_ok), 1);
    clear_cause(6'b000001);
    chk("R8 write-one-to-clear", int'(cause), 0);

    vec = 16'hABCD; expect_boot(16'hABCD, 6'b000100); boots++;
    pulse_src(0, 1, rem);
    chk("R3 stretch after short watchdog", rem, STRETCH);
    wait_boot(boots);

    clear_cause(6'b111111);
    vec = 16'h5A00; expect_boot(16'h5A00, 6'b000100); boots++;
    pulse_src(0, 6, rem);
    chk("R3 stretch after held watchdog", rem, STRETCH);
    wait_boot(boots);
    clear_cause(6'b111111);

    @(negedge clk) begin op_exec = 1; opcode = 8'hFF; dbg_mode = 1; end
    @(negedge clk) begin op_exec = 0; dbg_mode = 0; end
    repeat (3) @(negedge clk);
    chk("R4 debug blocks opcode reset", int'({sys_rst, cause}), 0);
    @(negedge clk) begin op_exec = 1; opcode = 8'hFE; end
    @(negedge clk) begin op_exec = 0; opcode = 0; end
    repeat (3) @(negedge clk);
    chk("R4 other opcode ignored", int'({sys_rst, cause}), 0);
    @(negedge clk) begin op_exec = 0; opcode = 8'hFF; end
    @(negedge clk) opcode = 0;
    repeat (3) @(negedge clk);
    chk("R4 opcode without execute ignored", int'({sys_rst, cause}), 0);
    vec = 16'h0F0F; expect_boot(16'h0F0F, 6'b001000); boots++;
    pulse_src(1, 1, rem);
    chk("R4 illegal opcode stretch", rem, STRETCH);
    wait_boot(boots);
    clear_cause(6'b111111);

    vec = 16'h8001; expect_boot(16'h8001, 6'b010000); boots++;
    @(negedge clk) ret_fault = 1;
    @(negedge clk) ret_fault = 0;
    chk("R6 retention releases pin A", int'({pin_a_oe, pin_a_pu}), 0);
    chk("R7 retention keeps pin B pull-up", int'(pin_b_pu), 1);
    chk("R5 retention osc off", int'(osc_en), 0);
    wait_boot(boots);
    clear_cause(6'b111111);

    vec = 16'hFFFF; expect_boot(16'hFFFF, 6'b100000); boots++;
    @(negedge clk) mem_fault = 1;
    @(negedge clk) mem_fault = 0;
    chk("R6 memory fault drives pin A", int'({pin_a_oe, pin_a_pu}), 3);
    wait_boot(boots);

    ext_pulse(MIN_LOW - 1, seen, aoe, bpu);
    chk("R1 short pulse no reset", seen, 0);
    chk("R1 short pulse cause kept", int'(cause), 6'b100000);
    pin_rst_en = 0;
    ext_pulse(3 * MIN_LOW, seen, aoe, bpu);
    chk("R2 disabled pin no reset", seen, 0);
    chk("R2 disabled pin cause kept", int'(cause), 6'b100000);
    pin_rst_en = 1;

    vec = 16'h2468; expect_boot(16'h2468, 6'b000010); boots++;
    ext_pulse(MIN_LOW, seen, aoe, bpu);
    chk("R1 exact width accepted", int'(seen > 0), 1);
    chk("R6 external releases pin A", aoe, 0);
    chk("R7 external pulls pin B low", bpu, 0);
    chk("R8 external clears other flags", int'(cause), 6'b000010);
    wait_boot(boots);

    vec = 16'h1357; expect_boot(16'h1357, 6'b000010); boots++;
    ext_pulse(2 * MIN_LOW, seen, aoe, bpu);
    chk("R1 long pulse accepted", int'(seen > 0), 1);
    wait_boot(boots);
    clear_cause(6'b111111);

    ack_en = 0;
    pulse_src(0, 1, rem);
    repeat (3) @(negedge clk);
    chk("R9 waits at low byte", int'({mem_req, mem_addr}), 17'h10000);
    vec = 16'h7E81; expect_boot(16'h7E81, 6'b100100); boots++;
    @(negedge clk) mem_fault = 1;
    @(negedge clk) mem_fault = 0;
    ack_en = 1;
    chk("R10 fetch abandoned", int'({mem_req, cpu_start}), 0);
    wait_boot(boots);
    repeat (10) @(negedge clk);
    chk("R10 exactly one boot", popped, boots);
    chk("R9 queue drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule